// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the distribution stage of a small interrupt controller. It samples peripheral interrupt lines, keeps per-interrupt enable, pending, trigger and routing state, and accepts software-raised interrupts. For every CPU it presents the single most urgent interrupt that is pending, enabled and routed to that CPU, as an ID and a priority. A separate per-CPU interface consumes that result and returns an acknowledge strobe.

Software reaches the state through a 32-bit register port with a byte address and a CPU number attached to each access. IDs 0 to 31 are private to each CPU: IDs 0 to 15 are software-raised, IDs 16 to 31 come from per-CPU peripheral lines, and their enable, pending and trigger bits exist once per CPU. IDs 32 and up are shared lines routed by a per-interrupt CPU target mask. Defaults are 64 IDs and 2 CPUs.

Register layout (byte offsets): control 0x000 (bit 0 forwarding enable), type 0x004 (read-only), software trigger 0x008, enable-set 0x100, enable-clear 0x140, pending status 0x180 (read-only), priority 0x400, target 0x600, trigger configuration 0x800. Word n of the enable, pending and configuration windows covers IDs from 32n (16n for configuration); word 0 of those windows is the banked copy of the accessing CPU.

Top module: `irq_distributor`

## Requirements
- R1: After reset no CPU output is valid, the control register reads 0 and all enable words read 0.
- R2: Writing 1 to a bit of the enable-set window (0x100 + 4n) enables interrupt 32n+bit and writing 1 to the enable-clear window (0x140 + 4n) disables it; 0 bits change nothing, and both windows read the current enables.
- R3: The type register at 0x004 reads (IDs/32 - 1) in bits 4:0 and 0 elsewhere, which is 1 for 64 IDs.
- R4: While control bit 0 is 0 no CPU output is valid, and pending state is kept for when it is set again.
- R5: With the upper bit (bit 2k+1) of its configuration field set, an interrupt becomes pending on a rising edge of its line and stays pending after the line falls, until acknowledged.
- R6: With that bit clear (level mode, the reset value) an interrupt is pending exactly while its line is high; an acknowledge while the line is still high leaves it pending.
- R7: Configuration word 0 (IDs 0-15) always reads 0xAAAAAAAA (edge) and writes to it are ignored.
- R8: For IDs 0-31, enable, pending and configuration accesses reach the copy of the CPU given on the bus, and per-CPU lines forward only to their own CPU.
- R9: A write to 0x008 makes the ID in bits 3:0 pending on each CPU c whose bit 16+c is set, and on no other CPU.
- R10: A shared interrupt is forwarded to CPU c only when bit c of its target byte (byte id%4 of word 0x600 + 4*(id/4)) is set; the target bytes read back.
- R11: Each CPU output carries the eligible interrupt with the lowest priority value; on equal priority the lower ID wins.
- R12: An acknowledge strobe from CPU c with an ID clears that ID's pending bit in CPU c's private copy (IDs below 32) or the shared bit (IDs 32 and up), leaving other CPUs' private copies untouched.
- R13: Priority bytes (byte id%4 of word 0x400 + 4*(id/4)) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cpu | input | CIDW | CPU number of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_in | input | NUM_IRQ-32 | Shared interrupt lines, bit i is ID 32+i |
| ppi_in | input | NUM_CPU*16 | Private lines, bit 16c+k is ID 16+k of CPU c |
| ack_valid | input | NUM_CPU | Acknowledge strobe per CPU |
| ack_id | input | NUM_CPU*IDW | Acknowledged ID per CPU |
| best_valid | output | NUM_CPU | An interrupt is offered to the CPU |
| best_id | output | NUM_CPU*IDW | ID offered to each CPU |
| best_prio | output | NUM_CPU*8 | Priority of the offered ID |

## Verification
On every cycle the assertions check that a cleared forwarding enable leaves all outputs invalid the cycle after, that a pending edge-mode shared interrupt is held until some CPU acknowledges it, that such an acknowledge clears it unless a new edge arrives together with it, and that enable-set writes reach the shared enables. The arbitration order, the target routing, the private copies selected by the bus CPU number, the software trigger lists and the fixed configuration of the software IDs can only be shown by the bench scenarios, which compare outputs and register reads against values worked out from the requirements.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int PW = 8;

  // word indices (byte address / 4) of the register windows
  localparam logic [9:0] W_CTRL = 10'h000;
  localparam logic [9:0] W_TYPE = 10'h001;
  localparam logic [9:0] W_SGI  = 10'h002;
  localparam logic [9:0] W_ENS  = 10'h040;
  localparam logic [9:0] W_ENC  = 10'h050;
  localparam logic [9:0] W_PEND = 10'h060;
  localparam logic [9:0] W_PRIO = 10'h100;
  localparam logic [9:0] W_TGT  = 10'h180;
  localparam logic [9:0] W_CFG  = 10'h200;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_SGI, RG_ENS,
    RG_ENC, RG_PEND, RG_PRIO, RG_TGT, RG_CFG
  } region_e;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int N   = 64,
  parameter int PW  = 8,
  parameter int IDW = 6
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            sel_valid,
  output logic [IDW-1:0]  sel_id,
  output logic [PW-1:0]   sel_prio
);
  // upward scan with strict compare: ties keep the lower ID
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    sel_prio  = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!sel_valid || prio[i*PW +: PW] < sel_prio)) begin
        sel_valid = 1'b1;
        sel_id    = IDW'(i);
        sel_prio  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  localparam int IDW  = $clog2(NUM_IRQ),
  localparam int CIDW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CIDW-1:0]        bus_cpu,
  input  logic                   bus_wr,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_IRQ-33:0]    spi_in,
  input  logic [NUM_CPU*16-1:0]  ppi_in,
  input  logic [NUM_CPU-1:0]     ack_valid,
  input  logic [NUM_CPU*IDW-1:0] ack_id,
  output logic [NUM_CPU-1:0]     best_valid,
  output logic [NUM_CPU*IDW-1:0] best_id,
  output logic [NUM_CPU*PW-1:0]  best_prio
);
  localparam int NSH  = NUM_IRQ - 32;
  localparam int NENW = NUM_IRQ / 32;
  localparam int NPRW = NUM_IRQ / 4;
  localparam int NCFW = NUM_IRQ / 16;
  localparam logic [9:0] ENW10 = 10'(NENW);
  localparam logic [9:0] PRW10 = 10'(NPRW);
  localparam logic [9:0] CFW10 = 10'(NCFW);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  // architectural state
  logic                              ctrl_q, ctrl_d;
  logic [NUM_CPU-1:0][31:0]          en_bank_q, en_bank_d, pend_bank_q, pend_bank_d;
  logic [NUM_CPU-1:0][15:0]          cfgp_q, cfgp_d;
  logic [NSH-1:0]                    en_sh_q, en_sh_d, pend_sh_q, pend_sh_d, cfg_sh_q, cfg_sh_d;
  logic [NUM_IRQ-1:0][PW-1:0]        prio_q, prio_d;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0]   tgt_q, tgt_d;

  // line conditioning
  logic [NSH-1:0]           spi_lvl, spi_rise;
  logic [NUM_CPU-1:0][15:0] ppi_lvl, ppi_rise;

  irq_line_sync #(.W(NSH)) u_spi_sync (
    .clk(clk), .rst_n(rst_s_n), .din(spi_in), .lvl(spi_lvl), .rise(spi_rise)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_ppi
    irq_line_sync #(.W(16)) u_ppi_sync (
      .clk(clk), .rst_n(rst_s_n), .din(ppi_in[c*16 +: 16]),
      .lvl(ppi_lvl[c]), .rise(ppi_rise[c])
    );
  end

  // address decode
  logic [9:0] widx, off;
  region_e    rg;
  assign widx = bus_addr[11:2];

  always_comb begin
    rg  = RG_NONE;
    off = '0;
    if (widx == W_CTRL)                               rg = RG_CTRL;
    else if (widx == W_TYPE)                          rg = RG_TYPE;
    else if (widx == W_SGI)                           rg = RG_SGI;
    else if (widx >= W_ENS && widx < W_ENS + ENW10)   begin rg = RG_ENS;  off = widx - W_ENS;  end
    else if (widx >= W_ENC && widx < W_ENC + ENW10)   begin rg = RG_ENC;  off = widx - W_ENC;  end
    else if (widx >= W_PEND && widx < W_PEND + ENW10) begin rg = RG_PEND; off = widx - W_PEND; end
    else if (widx >= W_PRIO && widx < W_PRIO + PRW10) begin rg = RG_PRIO; off = widx - W_PRIO; end
    else if (widx >= W_TGT && widx < W_TGT + PRW10)   begin rg = RG_TGT;  off = widx - W_TGT;  end
    else if (widx >= W_CFG && widx < W_CFG + CFW10)   begin rg = RG_CFG;  off = widx - W_CFG;  end
  end

  // acknowledge and software trigger decode
  logic [NUM_CPU-1:0][31:0] clr_bank;
  logic [NUM_CPU-1:0][15:0] sgi_set;
  logic [NSH-1:0]           clr_sh;

  always_comb begin
    clr_bank = '0;
    clr_sh   = '0;
    sgi_set  = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int i = 0; i < 32; i++)
        if (ack_valid[c] && ack_id[c*IDW +: IDW] == IDW'(i)) clr_bank[c][i] = 1'b1;
      for (int i = 0; i < NSH; i++)
        if (ack_valid[c] && ack_id[c*IDW +: IDW] == IDW'(i + 32)) clr_sh[i] = 1'b1;
      for (int i = 0; i < 16; i++)
        if (bus_wr && rg == RG_SGI && bus_wdata[16+c] && bus_wdata[3:0] == 4'(i))
          sgi_set[c][i] = 1'b1;
    end
  end

  // next state
  always_comb begin
    ctrl_d    = ctrl_q;
    en_bank_d = en_bank_q;
    en_sh_d   = en_sh_q;
    cfgp_d    = cfgp_q;
    cfg_sh_d  = cfg_sh_q;
    prio_d    = prio_q;
    tgt_d     = tgt_q;

    for (int c = 0; c < NUM_CPU; c++) begin
      for (int i = 0; i < 16; i++)
        pend_bank_d[c][i] = (pend_bank_q[c][i] & ~clr_bank[c][i]) | sgi_set[c][i];
      for (int k = 0; k < 16; k++)
        pend_bank_d[c][16+k] = cfgp_q[c][k]
          ? ((pend_bank_q[c][16+k] & ~clr_bank[c][16+k]) | ppi_rise[c][k])
          : ppi_lvl[c][k];
    end
    for (int i = 0; i < NSH; i++)
      pend_sh_d[i] = cfg_sh_q[i] ? ((pend_sh_q[i] & ~clr_sh[i]) | spi_rise[i]) : spi_lvl[i];

    if (bus_wr) begin
      if (rg == RG_CTRL) ctrl_d = bus_wdata[0];
      for (int w = 0; w < NENW; w++) begin
        if (off == 10'(w) && (rg == RG_ENS || rg == RG_ENC)) begin
          if (w == 0) begin
            for (int c = 0; c < NUM_CPU; c++)
              if (bus_cpu == CIDW'(c))
                en_bank_d[c] = (rg == RG_ENS) ? (en_bank_q[c] | bus_wdata)
                                              : (en_bank_q[c] & ~bus_wdata);
          end else begin
            en_sh_d[(w-1)*32 +: 32] = (rg == RG_ENS) ? (en_sh_q[(w-1)*32 +: 32] | bus_wdata)
                                                     : (en_sh_q[(w-1)*32 +: 32] & ~bus_wdata);
          end
        end
      end
      for (int w = 0; w < NPRW; w++)
        for (int b = 0; b < 4; b++) begin
          if (rg == RG_PRIO && off == 10'(w)) prio_d[w*4+b] = bus_wdata[b*8 +: PW];
          if (rg == RG_TGT && off == 10'(w))  tgt_d[w*4+b]  = bus_wdata[b*8 +: NUM_CPU];
        end
      // configuration word 0 (software IDs) is fixed: no branch for it
      for (int w = 1; w < NCFW; w++)
        if (rg == RG_CFG && off == 10'(w))
          for (int k = 0; k < 16; k++) begin
            if (w == 1) begin
              for (int c = 0; c < NUM_CPU; c++)
                if (bus_cpu == CIDW'(c)) cfgp_d[c][k] = bus_wdata[2*k+1];
            end else begin
              cfg_sh_d[(w-2)*16+k] = bus_wdata[2*k+1];
            end
          end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q      <= 1'b0;
      en_bank_q   <= '0;
      pend_bank_q <= '0;
      cfgp_q      <= '0;
      en_sh_q     <= '0;
      pend_sh_q   <= '0;
      cfg_sh_q    <= '0;
      prio_q      <= '0;
      tgt_q       <= '0;
    end else begin
      ctrl_q      <= ctrl_d;
      en_bank_q   <= en_bank_d;
      pend_bank_q <= pend_bank_d;
      cfgp_q      <= cfgp_d;
      en_sh_q     <= en_sh_d;
      pend_sh_q   <= pend_sh_d;
      cfg_sh_q    <= cfg_sh_d;
      prio_q      <= prio_d;
      tgt_q       <= tgt_d;
    end
  end

  // per-CPU selection and output registers
  logic [NUM_CPU-1:0]     sel_valid;
  logic [NUM_CPU*IDW-1:0] sel_id;
  logic [NUM_CPU*PW-1:0]  sel_prio;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] cand;
    always_comb begin
      cand[31:0] = en_bank_q[c] & pend_bank_q[c];
      for (int i = 0; i < NSH; i++)
        cand[32+i] = en_sh_q[i] & pend_sh_q[i] & tgt_q[32+i][c];
    end

    irq_prio_select #(.N(NUM_IRQ), .PW(PW), .IDW(IDW)) u_sel (
      .cand(cand), .prio(prio_q),
      .sel_valid(sel_valid[c]), .sel_id(sel_id[c*IDW +: IDW]), .sel_prio(sel_prio[c*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      best_valid <= '0;
      best_id    <= '0;
      best_prio  <= '0;
    end else begin
      best_valid <= sel_valid & {NUM_CPU{ctrl_q}};
      best_id    <= sel_id;
      best_prio  <= sel_prio;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    unique case (rg)
      RG_CTRL: bus_rdata[0] = ctrl_q;
      RG_TYPE: bus_rdata[4:0] = 5'(NUM_IRQ/32 - 1);
      RG_ENS, RG_ENC, RG_PEND: begin
        for (int w = 0; w < NENW; w++)
          if (off == 10'(w)) begin
            if (w == 0) begin
              for (int c = 0; c < NUM_CPU; c++)
                if (bus_cpu == CIDW'(c))
                  bus_rdata = (rg == RG_PEND) ? pend_bank_q[c] : en_bank_q[c];
            end else begin
              bus_rdata = (rg == RG_PEND) ? pend_sh_q[(w-1)*32 +: 32] : en_sh_q[(w-1)*32 +: 32];
            end
          end
      end
      RG_PRIO, RG_TGT: begin
        for (int w = 0; w < NPRW; w++)
          if (off == 10'(w))
            for (int b = 0; b < 4; b++) begin
              if (rg == RG_PRIO) bus_rdata[b*8 +: PW] = prio_q[w*4+b];
              else               bus_rdata[b*8 +: NUM_CPU] = tgt_q[w*4+b];
            end
      end
      RG_CFG: begin
        for (int w = 0; w < NCFW; w++)
          if (off == 10'(w))
            for (int k = 0; k < 16; k++) begin
              if (w == 0) bus_rdata[2*k+1] = 1'b1;
              else if (w == 1) begin
                for (int c = 0; c < NUM_CPU; c++)
                  if (bus_cpu == CIDW'(c)) bus_rdata[2*k+1] = cfgp_q[c][k];
              end else bus_rdata[2*k+1] = cfg_sh_q[(w-2)*16+k];
            end
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  localparam int IDW = $clog2(NUM_IRQ),
  localparam int NSH = NUM_IRQ - 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctrl_q,
  input logic [NUM_CPU-1:0]     best_valid,
  input logic [NSH-1:0]         cfg_sh,
  input logic [NSH-1:0]         pend_sh,
  input logic [NSH-1:0]         rise_sh,
  input logic [NSH-1:0]         en_sh,
  input logic [NUM_CPU-1:0]     ack_valid,
  input logic [NUM_CPU*IDW-1:0] ack_id,
  input logic                   bus_wr,
  input logic [11:0]            bus_addr,
  input logic [31:0]            bus_wdata
);
  logic [NSH-1:0] ack_hit;
  always_comb begin
    ack_hit = '0;
    for (int i = 0; i < NSH; i++)
      for (int c = 0; c < NUM_CPU; c++)
        if (ack_valid[c] && ack_id[c*IDW +: IDW] == IDW'(i + 32)) ack_hit[i] = 1'b1;
  end

  // R4: forwarding disabled means no valid output on the next cycle
  p_fwd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q |=> (best_valid == '0));

  for (genvar i = 0; i < NSH; i++) begin : g_sh
    localparam logic [11:0] ENS_ADDR = 12'(32'h100 + 4 * (1 + i / 32));

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sh[i] && pend_sh[i] && !ack_hit[i]) |=> pend_sh[i]);

    p_ack_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sh[i] && ack_hit[i] && !rise_sh[i]) |=> !pend_sh[i]);

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ENS_ADDR && bus_wdata[i % 32]) |=> en_sh[i]);
  end
endmodule

bind irq_distributor irq_distributor_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .best_valid(best_valid),
  .cfg_sh(cfg_sh_q), .pend_sh(pend_sh_q), .rise_sh(spi_rise), .en_sh(en_sh_q),
  .ack_valid(ack_valid), .ack_id(ack_id),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/irq_distributor_bench.sv
module irq_distributor_bench;
  localparam int NI = 64, NC = 2, IDW = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [0:0]        bus_cpu;
  logic              bus_wr;
  logic [11:0]       bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NI-33:0]    spi_in;
  logic [NC*16-1:0]  ppi_in;
  logic [NC-1:0]     ack_valid;
  logic [NC*IDW-1:0] ack_id;
  logic [NC-1:0]     best_valid;
  logic [NC*IDW-1:0] best_id;
  logic [NC*8-1:0]   best_prio;

  always #5 clk = ~clk;

  irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC)) u_irq_distributor (
    .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_in(spi_in), .ppi_in(ppi_in),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio)
  );

  typedef struct {
    bit          is_rd;
    int          cpu;
    bit          v;
    int          id;
    int          pr;
    logic [31:0] data;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        n_run++;
        if (e.is_rd) begin
          if (bus_rdata !== e.data) begin
            n_fail++;
            $display("FAIL %s: rdata actual %h expected %h", e.tag, bus_rdata, e.data);
          end
        end else begin
          if (best_valid[e.cpu] !== e.v ||
              (e.v && (best_id[e.cpu*IDW +: IDW] != 6'(e.id) || best_prio[e.cpu*8 +: 8] != 8'(e.pr)))) begin
            n_fail++;
            $display("FAIL %s: cpu%0d actual v=%0b id=%0d pr=%h expected v=%0b id=%0d pr=%h",
                     e.tag, e.cpu, best_valid[e.cpu], best_id[e.cpu*IDW +: IDW],
                     best_prio[e.cpu*8 +: 8], e.v, e.id, e.pr);
          end
        end
      end
    end
  end

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_cpu = 1'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input int cpu, input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t e;
    @(posedge clk); #1;
    bus_cpu = 1'(cpu); bus_addr = a;
    e.is_rd = 1; e.cpu = cpu; e.v = 0; e.id = 0; e.pr = 0; e.data = exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk_out(input int cpu, input bit v, input int id, input int pr, input string tag);
    item_t e;
    @(posedge clk); #1;
    e.is_rd = 0; e.cpu = cpu; e.v = v; e.id = id; e.pr = pr; e.data = '0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ack(input int cpu, input int id);
    @(posedge clk); #1;
    ack_valid[cpu] = 1'b1; ack_id[cpu*IDW +: IDW] = 6'(id);
    @(posedge clk); #1;
    ack_valid[cpu] = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_cpu = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    spi_in = '0; ppi_in = '0; ack_valid = '0; ack_id = '0;
    settle(4);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    chk_out(0, 0, 0, 0, "R1 cpu0 idle");
    chk_out(1, 0, 0, 0, "R1 cpu1 idle");
    chk_rd(0, 12'h000, 32'h0, "R1 ctrl");
    chk_rd(0, 12'h104, 32'h0, "R1 enables");
    // R3 type
    chk_rd(0, 12'h004, 32'h1, "R3 type");

    // R2 set/clear windows
    wr(0, 12'h104, 32'h5);
    chk_rd(0, 12'h104, 32'h5, "R2 set window");
    chk_rd(0, 12'h144, 32'h5, "R2 clear window read");
    wr(0, 12'h104, 32'h0);
    chk_rd(0, 12'h104, 32'h5, "R2 zero write");
    wr(0, 12'h144, 32'h4);
    chk_rd(0, 12'h104, 32'h1, "R2 clear");

    // R13 priorities, R10 targets
    wr(0, 12'h420, 32'h00203040);
    chk_rd(0, 12'h420, 32'h00203040, "R13 prio readback");
    wr(0, 12'h620, 32'h03020301);
    chk_rd(1, 12'h620, 32'h03020301, "R10 target readback");
    wr(0, 12'h104, 32'hF);
    wr(0, 12'h000, 32'h1);

    // level lines, routing, arbitration
    spi_in[0] = 1'b1; settle(8);
    chk_out(0, 1, 32, 8'h40, "R6 level pend cpu0");
    chk_out(1, 0, 0, 0, "R10 not routed cpu1");
    spi_in[1] = 1'b1; settle(8);
    chk_out(0, 1, 33, 8'h30, "R11 lower value wins");
    chk_out(1, 1, 33, 8'h30, "R10 both targets");
    spi_in[2] = 1'b1; settle(8);
    chk_out(0, 1, 33, 8'h30, "R10 id34 not to cpu0");
    chk_out(1, 1, 34, 8'h20, "R11 cpu1 best");
    spi_in = '0; settle(8);
    chk_out(0, 0, 0, 0, "R6 level drop cpu0");
    chk_out(1, 0, 0, 0, "R6 level drop cpu1");

    // R11 tie
    wr(0, 12'h420, 32'h10101010);
    spi_in[1] = 1'b1; spi_in[3] = 1'b1; settle(8);
    chk_out(0, 1, 33, 8'h10, "R11 tie lower id");
    spi_in[1] = 1'b0; settle(8);
    chk_out(0, 1, 35, 8'h10, "R11 remaining id");
    // R6 ack with line still high
    ack(0, 35); settle(8);
    chk_out(0, 1, 35, 8'h10, "R6 ack keeps level");
    spi_in = '0; settle(8);
    chk_out(0, 0, 0, 0, "R6 idle");

    // R5 edge mode
    wr(0, 12'h808, 32'h2);
    chk_rd(0, 12'h808, 32'h2, "R5 cfg readback");
    spi_in[0] = 1'b1; settle(3); spi_in[0] = 1'b0; settle(8);
    chk_out(0, 1, 32, 8'h10, "R5 edge held");
    chk_out(1, 0, 0, 0, "R10 edge not cpu1");
    ack(0, 32); settle(8);
    chk_out(0, 0, 0, 0, "R12 ack clears edge");

    // R4 forwarding off
    wr(0, 12'h000, 32'h0);
    spi_in[0] = 1'b1; settle(3); spi_in[0] = 1'b0; settle(8);
    chk_out(0, 0, 0, 0, "R4 gated");
    chk_rd(0, 12'h184, 32'h1, "R4 pending kept");
    wr(0, 12'h000, 32'h1); settle(4);
    chk_out(0, 1, 32, 8'h10, "R4 reenabled");
    ack(0, 32); settle(4);

    // R9 software trigger, R8 banking
    wr(1, 12'h100, 32'h8);
    wr(0, 12'h008, 32'h00030003); settle(4);
    chk_out(1, 1, 3, 8'h00, "R9 sgi cpu1");
    chk_out(0, 0, 0, 0, "R8 cpu0 bank disabled");
    chk_rd(0, 12'h100, 32'h0, "R8 enable bank cpu0");
    chk_rd(1, 12'h100, 32'h8, "R8 enable bank cpu1");
    chk_rd(0, 12'h180, 32'h8, "R9 pend cpu0");
    chk_rd(1, 12'h180, 32'h8, "R9 pend cpu1");
    ack(1, 3); settle(4);
    chk_out(1, 0, 0, 0, "R12 sgi acked");
    chk_rd(1, 12'h180, 32'h0, "R12 bank cleared");
    chk_rd(0, 12'h180, 32'h8, "R12 other bank kept");
    wr(0, 12'h008, 32'h00010005);
    chk_rd(0, 12'h180, 32'h28, "R9 target cpu0 only");
    chk_rd(1, 12'h180, 32'h0, "R9 cpu1 untouched");

    // R8 private lines
    wr(1, 12'h100, 32'h00100000);
    ppi_in[16+4] = 1'b1; settle(8);
    chk_out(1, 1, 20, 8'h00, "R8 ppi cpu1");
    chk_out(0, 0, 0, 0, "R8 ppi not cpu0");
    ppi_in = '0; settle(8);
    chk_out(1, 0, 0, 0, "R8 ppi drop");

    // R7 fixed software config, R8 banked config
    wr(0, 12'h800, 32'hFFFFFFFF);
    chk_rd(0, 12'h800, 32'hAAAAAAAA, "R7 sgi cfg fixed");
    wr(1, 12'h804, 32'h00000200);
    chk_rd(1, 12'h804, 32'h00000200, "R8 cfg bank cpu1");
    chk_rd(0, 12'h804, 32'h0, "R8 cfg bank cpu0");

    settle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule